// File: doc/BRIEF.md
# Modular Multiplier Self-Test Engine

This block puts a single-cycle W-bit modular multiplier, computing x·y mod P, behind two operand selectors so that the same arithmetic serves three jobs. When idle it acts as an ordinary modular multiplier with a valid/ready request and a registered result. During a self-test it first squares its own last output to make a pseudorandom stimulus sequence, each value being the square of the one before modulo P. It then multiplies the running signature by the response that the circuit under test returns, so the signature folds in one response per pattern.

A small controller alternates these two steps for a programmed number of patterns, spending one cycle on each step. After the last fold it compares the signature with a stored fault-free value and reports pass or fail. The modulus, the starting seed, the starting signature, the pattern count and the expected signature are written through a configuration port before the test starts. A start request with an unusable configuration is refused and reported as an error.

Top module: `mmb_bist_engine`

## Requirements
- R1: When idle, `op_ready` is 1; a request with `op_valid` and `op_ready` both high at a clock edge gives `res_valid` = 1 in the next cycle with `res_data` = (`op_a` · `op_b`) mod P. Back-to-back requests are accepted every cycle. While a test runs, `op_ready` is 0 and no request is taken.
- R2: A write (`cfg_we` = 1) stores `cfg_data` into the register chosen by `cfg_addr`: 0 modulus P, 1 seed, 2 starting signature, 3 pattern count N, 4 expected signature. Writes made while `bist_busy` is 1 are ignored.
- R3: A start pulse while idle with an unusable configuration (P < 2, seed 0 or seed ≥ P, starting signature 0 or ≥ P, N = 0) runs no test; in the next cycle `bist_done` = 1, `bist_err` = 1, `bist_pass` = 0 and `bist_busy` = 0.
- R4: Pattern k (k = 1..N) is seed^(2^k) mod P; it appears on `cut_pattern` in a cycle where `cut_valid` is 1, once per pattern, in order.
- R5: The signature starts at the programmed starting value, and each fold replaces it by (response · signature) mod P, where the response is `cut_response` in the cycle `cut_valid` is 1.
- R6: After an accepted start, `bist_busy` is 1 for exactly 2·N cycles, starting the cycle after the start edge; `cut_valid` is 1 on the 2nd, 4th, ... of those cycles and never in two cycles running.
- R7: In the cycle `bist_busy` falls, `bist_done` becomes 1 and `bist_pass` is 1 exactly when the final signature equals the expected signature.
- R8: `bist_done`, `bist_pass` and `bist_err` hold their values until the next start pulse accepted while idle; a start pulse while busy is ignored and does not lengthen the test. An accepted valid start clears `bist_err`.
- R9: After reset, `bist_busy`, `bist_done`, `bist_pass`, `bist_err`, `res_valid` and `cut_valid` are 0 and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_data | input | W | Configuration write value |
| op_valid | input | 1 | Normal multiply request |
| op_ready | output | 1 | Normal request can be taken |
| op_a | input | W | First multiply operand |
| op_b | input | W | Second multiply operand |
| res_valid | output | 1 | Normal result present |
| res_data | output | W | Normal result, a·b mod P |
| bist_start | input | 1 | Self-test start pulse |
| bist_busy | output | 1 | Self-test running |
| bist_done | output | 1 | Self-test finished or refused |
| bist_pass | output | 1 | Signature matched the expected value |
| bist_err | output | 1 | Start refused for bad configuration |
| cut_pattern | output | W | Stimulus to the circuit under test |
| cut_valid | output | 1 | Stimulus present, response sampled this cycle |
| cut_response | input | W | Response from the circuit under test |

## Verification
The in-design properties take for granted that the circuit under test answers combinationally in the same cycle the stimulus is shown, and that the configuration stays put for the whole run; the second is enforced by the block itself, which is what lets the stimulus-below-modulus property hold. The bench's stand-in circuit maps each stimulus to a value between 1 and P−1, so the signature never collapses to zero, and it keeps the modulus at 2 or more at all times so its own reference model never divides by zero. Disturbances during a run (a second start, a config write, a multiply request) are issued only while the block reports busy, so their effect is visible in the run length and verdict.

// File: rtl/mmb_pkg.sv
// Package: shared encodings for the modular multiplier self-test engine.
// Assumes: nothing; pure type and constant definitions.
package mmb_pkg;

    // Controller phase
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SQUARE = 2'd1,
        PH_FOLD   = 2'd2
    } mmb_phase_e;

    // Operand source for the shared multiplier
    typedef enum logic [1:0] {
        SRC_OPERANDS = 2'd0,
        SRC_FEEDBACK = 2'd1,
        SRC_RESPONSE = 2'd2
    } mmb_src_e;

    localparam int unsigned CFG_ADDR_W = 3;

    localparam logic [CFG_ADDR_W-1:0] CFG_MODULUS = 3'd0;
    localparam logic [CFG_ADDR_W-1:0] CFG_SEED    = 3'd1;
    localparam logic [CFG_ADDR_W-1:0] CFG_SIG0    = 3'd2;
    localparam logic [CFG_ADDR_W-1:0] CFG_COUNT   = 3'd3;
    localparam logic [CFG_ADDR_W-1:0] CFG_GOLDEN  = 3'd4;

endpackage

// File: rtl/mmb_modmul.sv
// Module: single-cycle modular multiplier, r = x*y mod p.
// Assumes: combinational, full-width product; a zero modulus yields zero.
module mmb_modmul #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] p,
    output logic [W-1:0] r
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] product;
    logic [PW-1:0] remainder;

    // Form the double-width product and reduce it by the modulus
    always_comb begin
        product = {{W{1'b0}}, x} * {{W{1'b0}}, y};
        if (p == '0) begin
            remainder = '0;
        end else begin
            remainder = product % {{W{1'b0}}, p};
        end
        r = remainder[W-1:0];
    end

endmodule

// File: rtl/mmb_opmux.sv
// Module: the two operand selectors in front of the shared multiplier.
// Assumes: src is one of the three mmb_src_e values; others fall back to operands.
module mmb_opmux #(
    parameter int unsigned W = 16
) (
    input  mmb_pkg::mmb_src_e src,
    input  logic [W-1:0]      op_a,
    input  logic [W-1:0]      op_b,
    input  logic [W-1:0]      feedback,
    input  logic [W-1:0]      response,
    input  logic [W-1:0]      signature,
    output logic [W-1:0]      mul_x,
    output logic [W-1:0]      mul_y
);
    import mmb_pkg::*;

    localparam int unsigned LANES = 2;

    logic [W-1:0] lane_norm [LANES];
    logic [W-1:0] lane_fb   [LANES];
    logic [W-1:0] lane_tst  [LANES];
    logic [W-1:0] lane_out  [LANES];

    assign lane_norm[0] = op_a;
    assign lane_norm[1] = op_b;
    assign lane_fb[0]   = feedback;
    assign lane_fb[1]   = feedback;
    assign lane_tst[0]  = response;
    assign lane_tst[1]  = signature;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Pick this lane's operand from the source in use
        always_comb begin
            case (src)
                SRC_FEEDBACK: lane_out[g] = lane_fb[g];
                SRC_RESPONSE: lane_out[g] = lane_tst[g];
                default:      lane_out[g] = lane_norm[g];
            endcase
        end
    end

    assign mul_x = lane_out[0];
    assign mul_y = lane_out[1];

endmodule

// File: rtl/mmb_cfg_regs.sv
// Module: configuration registers and start-time validity check.
// Assumes: writes are single-cycle strobes; writes while busy are dropped.
module mmb_cfg_regs #(
    parameter int unsigned W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [mmb_pkg::CFG_ADDR_W-1:0] addr,
    input  logic [W-1:0]                  data,
    input  logic                          busy,
    output logic [W-1:0]                  modulus,
    output logic [W-1:0]                  seed,
    output logic [W-1:0]                  sig0,
    output logic [W-1:0]                  count,
    output logic [W-1:0]                  golden,
    output logic                          cfg_ok
);
    import mmb_pkg::*;

    localparam logic [W-1:0] MIN_MODULUS = W'(2);

    // Store a configuration write when no test is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            modulus <= '0;
            seed    <= '0;
            sig0    <= '0;
            count   <= '0;
            golden  <= '0;
        end else if (we && !busy) begin
            case (addr)
                CFG_MODULUS: modulus <= data;
                CFG_SEED:    seed    <= data;
                CFG_SIG0:    sig0    <= data;
                CFG_COUNT:   count   <= data;
                CFG_GOLDEN:  golden  <= data;
                default:     ;
            endcase
        end
    end

    // Decide whether the stored configuration can run a test
    always_comb begin
        cfg_ok = (modulus >= MIN_MODULUS)
              && (seed != '0) && (seed < modulus)
              && (sig0 != '0) && (sig0 < modulus)
              && (count != '0);
    end

    // R2: configuration cannot move while a test is running
    a_r2_cfg_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({modulus, seed, sig0, count, golden}));

endmodule

// File: rtl/mmb_ctrl.sv
// Module: self-test sequencer; alternates square and fold phases and
// keeps the stimulus, signature, count and verdict registers.
// Assumes: cut response is valid combinationally while cut_valid is high;
// configuration is frozen by the register block while busy.
module mmb_ctrl #(
    parameter int unsigned W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_ok,
    input  logic [W-1:0]      count,
    input  logic [W-1:0]      seed,
    input  logic [W-1:0]      sig0,
    input  logic [W-1:0]      golden,
    input  logic [W-1:0]      product,
    output mmb_pkg::mmb_src_e src,
    output logic [W-1:0]      stim,
    output logic [W-1:0]      signature,
    output logic              cut_valid,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              err
);
    import mmb_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    mmb_phase_e   phase;
    logic [W-1:0] folded;
    logic         last_fold;

    assign last_fold = (folded == count - ONE);

    // Sequence the test and update stimulus, signature and verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            stim      <= '0;
            signature <= '0;
            folded    <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            err       <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (cfg_ok) begin
                            phase     <= PH_SQUARE;
                            stim      <= seed;
                            signature <= sig0;
                            folded    <= '0;
                            done      <= 1'b0;
                            pass      <= 1'b0;
                            err       <= 1'b0;
                        end else begin
                            done <= 1'b1;
                            pass <= 1'b0;
                            err  <= 1'b1;
                        end
                    end
                end
                PH_SQUARE: begin
                    stim  <= product;
                    phase <= PH_FOLD;
                end
                PH_FOLD: begin
                    signature <= product;
                    if (last_fold) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        pass  <= (product == golden);
                    end else begin
                        folded <= folded + ONE;
                        phase  <= PH_SQUARE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Map the phase to operand source and status
    always_comb begin
        case (phase)
            PH_SQUARE: src = SRC_FEEDBACK;
            PH_FOLD:   src = SRC_RESPONSE;
            default:   src = SRC_OPERANDS;
        endcase
        busy      = (phase != PH_IDLE);
        cut_valid = (phase == PH_FOLD);
    end

    // R6: folds never happen in two cycles running
    a_r6_fold_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        cut_valid |=> !cut_valid);

    // R7: finished and running are exclusive
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R8: the finished flag holds until a new start
    a_r8_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R3: a refused start reports an error and never a pass
    a_r3_refused_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !cfg_ok) |=> (err && done && !pass && !busy));

    // R3: an error never coexists with a pass
    a_r3_err_not_pass: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !pass);

    // R6: an accepted start begins the run in the next cycle
    a_r6_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cfg_ok) |=> (busy && !cut_valid));

endmodule

// File: rtl/mmb_bist_engine.sv
// Module: top of the modular multiplier self-test engine. One shared
// multiplier serves normal requests, stimulus squaring and signature folding.
// Assumes: circuit under test answers in the same cycle as cut_valid.
module mmb_bist_engine #(
    parameter int unsigned W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [mmb_pkg::CFG_ADDR_W-1:0] cfg_addr,
    input  logic [W-1:0]                  cfg_data,
    input  logic                          op_valid,
    output logic                          op_ready,
    input  logic [W-1:0]                  op_a,
    input  logic [W-1:0]                  op_b,
    output logic                          res_valid,
    output logic [W-1:0]                  res_data,
    input  logic                          bist_start,
    output logic                          bist_busy,
    output logic                          bist_done,
    output logic                          bist_pass,
    output logic                          bist_err,
    output logic [W-1:0]                  cut_pattern,
    output logic                          cut_valid,
    input  logic [W-1:0]                  cut_response
);
    import mmb_pkg::*;

    logic [W-1:0] modulus;
    logic [W-1:0] seed;
    logic [W-1:0] sig0;
    logic [W-1:0] count;
    logic [W-1:0] golden;
    logic         cfg_ok;
    mmb_src_e     src;
    logic [W-1:0] stim;
    logic [W-1:0] signature;
    logic [W-1:0] mul_x;
    logic [W-1:0] mul_y;
    logic [W-1:0] product;
    logic         accept;

    mmb_cfg_regs #(.W(W)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .data    (cfg_data),
        .busy    (bist_busy),
        .modulus (modulus),
        .seed    (seed),
        .sig0    (sig0),
        .count   (count),
        .golden  (golden),
        .cfg_ok  (cfg_ok)
    );

    mmb_opmux #(.W(W)) i_mux (
        .src       (src),
        .op_a      (op_a),
        .op_b      (op_b),
        .feedback  (stim),
        .response  (cut_response),
        .signature (signature),
        .mul_x     (mul_x),
        .mul_y     (mul_y)
    );

    mmb_modmul #(.W(W)) i_mul (
        .x (mul_x),
        .y (mul_y),
        .p (modulus),
        .r (product)
    );

    mmb_ctrl #(.W(W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bist_start),
        .cfg_ok    (cfg_ok),
        .count     (count),
        .seed      (seed),
        .sig0      (sig0),
        .golden    (golden),
        .product   (product),
        .src       (src),
        .stim      (stim),
        .signature (signature),
        .cut_valid (cut_valid),
        .busy      (bist_busy),
        .done      (bist_done),
        .pass      (bist_pass),
        .err       (bist_err)
    );

    assign op_ready    = !bist_busy;
    assign accept      = op_valid && op_ready;
    assign cut_pattern = stim;

    // Register the result of an accepted normal request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= accept;
            if (accept) begin
                res_data <= product;
            end
        end
    end

    // R1: a result only follows an accepted request
    a_r1_result_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(op_valid && !bist_busy));

    // R4: every stimulus shown to the circuit under test is reduced
    a_r4_pattern_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        cut_valid |-> (cut_pattern < modulus));

endmodule

// File: tb/test_mmb_bist_engine.sv
`timescale 1ns/1ps
module test_mmb_bist_engine;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_we;
    logic [2:0]   cfg_addr;
    logic [W-1:0] cfg_data;
    logic         op_valid;
    logic         op_ready;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         res_valid;
    logic [W-1:0] res_data;
    logic         bist_start;
    logic         bist_busy;
    logic         bist_done;
    logic         bist_pass;
    logic         bist_err;
    logic [W-1:0] cut_pattern;
    logic         cut_valid;
    logic [W-1:0] cut_response;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] cur_p = 16'd251;
    logic         fault_en = 1'b0;
    logic [W-1:0] res_q [$];
    logic [W-1:0] pat_q [$];

    always #2 clk = ~clk;

    mmb_bist_engine #(.W(W)) i_mmb_bist_engine (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
        .cfg_data (cfg_data), .op_valid (op_valid), .op_ready (op_ready),
        .op_a (op_a), .op_b (op_b), .res_valid (res_valid), .res_data (res_data),
        .bist_start (bist_start), .bist_busy (bist_busy), .bist_done (bist_done),
        .bist_pass (bist_pass), .bist_err (bist_err), .cut_pattern (cut_pattern),
        .cut_valid (cut_valid), .cut_response (cut_response)
    );

    function automatic logic [W-1:0] mulmod(input logic [W-1:0] a, b, p);
        logic [31:0] t;
        t = ({16'h0, a} * {16'h0, b}) % {16'h0, p};
        return t[W-1:0];
    endfunction

    // Stand-in circuit under test: maps a stimulus to 1..p-1
    function automatic logic [W-1:0] cut_model(input logic [W-1:0] pat, p, input logic flt);
        logic [31:0] t;
        logic [W-1:0] r;
        t = {16'h0, pat ^ 16'h00A5} % ({16'h0, p} - 32'd1);
        r = t[W-1:0] + 16'd1;
        if (flt) begin
            t = {16'h0, r} % ({16'h0, p} - 32'd1);
            r = t[W-1:0] + 16'd1;
        end
        return r;
    endfunction

    assign cut_response = cut_model(cut_pattern, cur_p, fault_en);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: pop and compare normal results and stimulus values
    always @(negedge clk) begin
        if (rst_n === 1'b1 && res_valid === 1'b1) begin
            if (res_q.size() == 0) check("R1 unexpected result", 32'd1, 32'd0);
            else check("R1 result", {16'h0, res_data}, {16'h0, res_q.pop_front()});
        end
        if (rst_n === 1'b1 && cut_valid === 1'b1) begin
            if (pat_q.size() == 0) check("R4 unexpected pattern", 32'd1, 32'd0);
            else check("R4 pattern", {16'h0, cut_pattern}, {16'h0, pat_q.pop_front()});
        end
    end

    task automatic cfg_write(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        if (a == 3'd0 && d >= 16'd2) cur_p = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_cfg(input logic [W-1:0] p, sd, s0, n, g);
        cfg_write(3'd0, p);
        cfg_write(3'd1, sd);
        cfg_write(3'd2, s0);
        cfg_write(3'd3, n);
        cfg_write(3'd4, g);
    endtask

    // Driver side: predict stimulus (pushed to queue) and final signature
    task automatic predict(input logic [W-1:0] p, sd, s0, input int n, input logic flt,
                           output logic [W-1:0] sig);
        logic [W-1:0] pat;
        pat = sd;
        sig = s0;
        for (int k = 0; k < n; k++) begin
            pat = mulmod(pat, pat, p);
            pat_q.push_back(pat);
            sig = mulmod(cut_model(pat, p, flt), sig, p);
        end
    endtask

    task automatic normal_op(input logic [W-1:0] a, b);
        @(negedge clk);
        check("R1 ready when idle", {31'h0, op_ready}, 32'd1);
        op_valid = 1'b1; op_a = a; op_b = b;
        res_q.push_back(mulmod(a, b, cur_p));
    endtask

    task automatic normal_idle();
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic run_bist(input int exp_cycles, input logic exp_pass, input logic disturb,
                            input logic [W-1:0] bad_golden);
        int busy_cnt = 0;
        int guard = 0;
        @(negedge clk);
        bist_start = 1'b1;
        @(negedge clk);
        bist_start = 1'b0;
        while (bist_done !== 1'b1 && guard < 20000) begin
            if (bist_busy === 1'b1) busy_cnt++;
            if (disturb) begin
                if (busy_cnt == 2) begin
                    check("R1 not ready while busy", {31'h0, op_ready}, 32'd0);
                    op_valid = 1'b1; op_a = 16'd7; op_b = 16'd9;
                end
                if (busy_cnt == 3) begin op_valid = 1'b0; bist_start = 1'b1; end
                if (busy_cnt == 4) bist_start = 1'b0;
                if (busy_cnt == 5) begin cfg_we = 1'b1; cfg_addr = 3'd4; cfg_data = bad_golden; end
                if (busy_cnt == 6) cfg_we = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        check("R6 busy cycles", busy_cnt, exp_cycles);
        check("R7 pass verdict", {31'h0, bist_pass}, {31'h0, exp_pass});
        check("R7 not busy at done", {31'h0, bist_busy}, 32'd0);
        check("R8 err cleared by valid start", {31'h0, bist_err}, 32'd0);
        check("R4 all patterns shown", pat_q.size(), 32'd0);
        pat_q.delete();
    endtask

    task automatic bad_start(input string tag);
        @(negedge clk);
        bist_start = 1'b1;
        @(negedge clk);
        bist_start = 1'b0;
        check({"R3 done ", tag}, {31'h0, bist_done}, 32'd1);
        check({"R3 err ", tag}, {31'h0, bist_err}, 32'd1);
        check({"R3 pass ", tag}, {31'h0, bist_pass}, 32'd0);
        check({"R3 busy ", tag}, {31'h0, bist_busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] gold;
        logic [W-1:0] gold_b;
        logic [W-1:0] faulty;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
        op_valid = 1'b0; op_a = '0; op_b = '0; bist_start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 busy", {31'h0, bist_busy}, 32'd0);
        check("R9 done", {31'h0, bist_done}, 32'd0);
        check("R9 pass", {31'h0, bist_pass}, 32'd0);
        check("R9 err", {31'h0, bist_err}, 32'd0);
        check("R9 res_valid", {31'h0, res_valid}, 32'd0);
        check("R9 cut_valid", {31'h0, cut_valid}, 32'd0);
        check("R9 op_ready", {31'h0, op_ready}, 32'd1);

        // R2 / R1: large prime modulus, normal mode back-to-back
        predict(16'd65521, 16'd3, 16'd1, 20, 1'b0, gold);
        pat_q.delete();
        load_cfg(16'd65521, 16'd3, 16'd1, 16'd20, gold);
        normal_op(16'd1234, 16'd5678);
        normal_op(16'hFFFF, 16'hFFFF);
        normal_op(16'd0, 16'd999);
        normal_op(16'd65520, 16'd2);
        normal_idle();
        @(negedge clk);
        check("R1 all results seen", res_q.size(), 32'd0);

        // R4 R5 R6 R7: fault-free run
        predict(16'd65521, 16'd3, 16'd1, 20, 1'b0, gold);
        run_bist(40, 1'b1, 1'b0, 16'd0);
        repeat (5) @(negedge clk);
        check("R8 done held", {31'h0, bist_done}, 32'd1);
        check("R8 pass held", {31'h0, bist_pass}, 32'd1);

        // R2 R8 R1: disturbances during the run have no effect
        predict(16'd65521, 16'd3, 16'd1, 20, 1'b0, gold);
        run_bist(40, 1'b1, 1'b1, gold ^ 16'h0001);
        check("R1 no result from busy request", res_q.size(), 32'd0);

        // R5 R7: faulty circuit under test
        fault_en = 1'b1;
        predict(16'd65521, 16'd3, 16'd1, 20, 1'b1, faulty);
        run_bist(40, (faulty == gold), 1'b0, 16'd0);
        fault_en = 1'b0;

        // R3: refused starts
        cfg_write(3'd1, 16'd0);
        bad_start("zero seed");
        cfg_write(3'd1, 16'd65521);
        bad_start("seed at modulus");
        cfg_write(3'd1, 16'd3);
        cfg_write(3'd3, 16'd0);
        bad_start("zero count");
        repeat (3) @(negedge clk);
        check("R8 err held", {31'h0, bist_err}, 32'd1);

        // R2 R4 R5 R6: small modulus, short run, clears the error
        predict(16'd251, 16'd7, 16'd5, 5, 1'b0, gold_b);
        load_cfg(16'd251, 16'd7, 16'd5, 16'd5, gold_b);
        normal_op(16'd300, 16'd17);
        normal_idle();
        @(negedge clk);
        run_bist(10, 1'b1, 1'b0, 16'd0);

        finish_run();
    end

endmodule